// File: doc/BRIEF.md
# Packed Decimal Adder

This block adds two unsigned decimal numbers held in packed binary-coded-decimal form, together with a one-bit carry in. It returns their decimal sum in the same packed form, along with a decimal carry out. Each decimal digit takes its own 4-bit group. Digit 0 is the least significant and sits in the lowest group. The number of digits is a parameter.

Every digit position adds its two input digits and the carry from the position below as a plain binary sum. If that sum is ten or more, the position adds six to bring the value back into the decimal range and passes a carry to the next digit up. The carry out of the top digit becomes the block's carry out. An error flag is raised when any input group holds a code from 10 to 15. The sum is undefined for such inputs.

The adder itself is combinational. A parameter places a register after it, which clears on reset, so that the result appears one clock after the operands.

Top module: `bcd_sum_unit`

## Requirements
- R1: Digit i of each operand and of the sum sits in bits [4i+3:4i], holds a value from 0 to 9, and has weight 10^i.
- R2: For valid operands, the sum output equals (a + b + carry_in) modulo 10^DIGITS, with every sum digit in the range 0 to 9.
- R3: carry_out is 1 exactly when a + b + carry_in is 10^DIGITS or more, given valid operands.
- R4: A digit whose binary sum is 10 to 15 outputs that sum minus ten and carries one into the next digit. For example, 5 + 5 gives digit 0 and a carry.
- R5: A digit whose binary sum is 16 to 19 also outputs that sum minus ten and carries. For example, 9 + 9 + 1 gives digit 9 and a carry.
- R6: A carry ripples through every digit in turn. For example, 9999 + 0001 gives 0000 with carry_out 1.
- R7: carry_in adds one to digit 0.
- R8: bad_digit is 1 when any 4-bit group of a or b exceeds 9, and 0 otherwise.
- R9: With REG_OUT = 1, the outputs follow the operands with exactly one clock of latency. While rst_n is low, sum_bcd, carry_out and bad_digit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| a_bcd | input | 4*DIGITS | First packed decimal operand |
| b_bcd | input | 4*DIGITS | Second packed decimal operand |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_bcd | output | 4*DIGITS | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top digit |
| bad_digit | output | 1 | Set when any operand group exceeds 9 |

## Verification
Every arithmetic property assumes operands whose groups are all in the range 0 to 9. Each property is therefore gated by a validity term rebuilt from the operands as they were when the result was formed. The random stimulus builds operands from decimal integers drawn below 10^DIGITS, which keeps them valid. Invalid codes are placed on purpose in a small share of cycles, and on those cycles only the flag is checked.

// File: rtl/bcd_sum_unit.sv
module bcd_sum_unit #(
  parameter int DIGITS  = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_bcd,
  input  logic [W-1:0] b_bcd,
  input  logic         carry_in,
  output logic [W-1:0] sum_bcd,
  output logic         carry_out,
  output logic         bad_digit
);

  logic [DIGITS:0]   dcarry;
  logic [W-1:0]      sum_c;
  logic [DIGITS-1:0] bad_v;

  assign dcarry[0] = carry_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [4:0] raw;
    assign raw = {1'b0, a_bcd[4*i +: 4]} + {1'b0, b_bcd[4*i +: 4]} + {4'd0, dcarry[i]};
    assign dcarry[i+1] = raw > 5'd9;
    assign sum_c[4*i +: 4] = dcarry[i+1] ? raw[3:0] + 4'd6 : raw[3:0];
    assign bad_v[i] = (a_bcd[4*i +: 4] > 4'd9) || (b_bcd[4*i +: 4] > 4'd9);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_bcd   <= '0;
        carry_out <= 1'b0;
        bad_digit <= 1'b0;
      end else begin
        sum_bcd   <= sum_c;
        carry_out <= dcarry[DIGITS];
        bad_digit <= |bad_v;
      end
    end
  end else begin : g_comb
    assign sum_bcd   = sum_c;
    assign carry_out = dcarry[DIGITS];
    assign bad_digit = |bad_v;
  end

endmodule

// File: rtl/bcd_sum_unit_chk.sv
module bcd_sum_unit_chk #(
  parameter int DIGITS  = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_bcd,
  input logic [W-1:0] b_bcd,
  input logic         carry_in,
  input logic [W-1:0] sum_bcd,
  input logic         carry_out,
  input logic         bad_digit
);

  logic [W-1:0] a_q, b_q, xa, xb, nines;
  logic         c_q, xc, primed, xvalid, sum_ok;
  int           low_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else begin
      primed <= 1'b1;
      a_q <= a_bcd;
      b_q <= b_bcd;
      c_q <= carry_in;
    end
  end

  assign xa = REG_OUT ? a_q : a_bcd;
  assign xb = REG_OUT ? b_q : b_bcd;
  assign xc = REG_OUT ? c_q : carry_in;

  always_comb begin
    xvalid = 1'b1;
    sum_ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      nines[4*i +: 4] = 4'd9;
      if (xa[4*i +: 4] > 4'd9 || xb[4*i +: 4] > 4'd9) xvalid = 1'b0;
      if (sum_bcd[4*i +: 4] > 4'd9) sum_ok = 1'b0;
    end
    low_ref = (int'(xa[3:0]) + int'(xb[3:0]) + int'(xc)) % 10;
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && xvalid) |-> sum_ok);                                              // R2
  AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && xvalid && xb == '0 && !xc) |-> (sum_bcd == xa && !carry_out));   // R2
  AST_LOW_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && xvalid) |-> (int'(sum_bcd[3:0]) == low_ref));                    // R4
  AST_ALL_NINES: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && xa == nines && xb == nines && xc) |-> (sum_bcd == nines && carry_out)); // R6
  AST_ZERO_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && xa == '0 && xb == '0) |-> (!bad_digit && sum_bcd == {{(W-1){1'b0}}, xc})); // R8

endmodule

bind bcd_sum_unit bcd_sum_unit_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_bcd(a_bcd), .b_bcd(b_bcd), .carry_in(carry_in),
  .sum_bcd(sum_bcd), .carry_out(carry_out), .bad_digit(bad_digit)
);

// File: tb/bcd_sum_unit_test.sv
module bcd_sum_unit_test;
  localparam int D = 4;
  localparam int W = 4 * D;
  localparam int LIMIT = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_bcd = '0, b_bcd = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum_bcd;
  logic carry_out, bad_digit;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_sum_unit #(.DIGITS(D), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .a_bcd(a_bcd), .b_bcd(b_bcd), .carry_in(carry_in),
    .sum_bcd(sum_bcd), .carry_out(carry_out), .bad_digit(bad_digit)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_dec(int x, int y, bit c, string req);
    int s;
    @(negedge clk);
    a_bcd = to_bcd(x); b_bcd = to_bcd(y); carry_in = c;
    @(posedge clk); #1;
    s = x + y + int'(c);
    check({req, " sum"}, 32'(sum_bcd), 32'(to_bcd(s % LIMIT)));
    check({req, " carry"}, 32'(carry_out), 32'(s >= LIMIT));
    check({req, " flag"}, 32'(bad_digit), 32'd0);
  endtask

  task automatic add_raw(logic [W-1:0] x, logic [W-1:0] y, bit expect_bad, string req);
    @(negedge clk);
    a_bcd = x; b_bcd = y; carry_in = 1'b0;
    @(posedge clk); #1;
    check(req, 32'(bad_digit), 32'(expect_bad));
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a_bcd = 16'h9999; b_bcd = 16'h9999; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset sum", 32'(sum_bcd), 32'd0);
    check("R9 reset carry", 32'(carry_out), 32'd0);
    check("R9 reset flag", 32'(bad_digit), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    add_dec(365, 0, 1'b0, "R1 encoding");
    add_dec(5, 5, 1'b0, "R4 ten");
    add_dec(7, 8, 1'b0, "R4 fifteen");
    add_dec(9, 9, 1'b1, "R5 nineteen");
    add_dec(8, 8, 1'b0, "R5 sixteen");
    add_dec(9999, 1, 1'b0, "R6 ripple");
    add_dec(9999, 9999, 1'b1, "R3 max");
    add_dec(0, 0, 1'b1, "R7 carry in");
    add_dec(4999, 5000, 1'b1, "R3 exact limit");
    add_raw(16'h00A0, 16'h0000, 1'b1, "R8 bad a");
    add_raw(16'h0000, 16'hF000, 1'b1, "R8 bad b top");
    add_raw(16'h9999, 16'h9999, 1'b0, "R8 nines valid");

    @(negedge clk); a_bcd = to_bcd(1234); b_bcd = to_bcd(4321); carry_in = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); a_bcd = to_bcd(1); b_bcd = to_bcd(1);
    #0.5;
    check("R9 latency hold", 32'(sum_bcd), 32'(to_bcd(5555)));
    @(posedge clk); #1;
    check("R9 latency next", 32'(sum_bcd), 32'(to_bcd(2)));

    for (int n = 0; n < 300; n++) begin
      if (n % 10 == 9) begin
        logic [W-1:0] x = to_bcd(int'($urandom % LIMIT));
        int pos = int'($urandom % D);
        x[4*pos +: 4] = 4'(10 + ($urandom % 6));
        add_raw(x, to_bcd(int'($urandom % LIMIT)), 1'b1, "R8 random bad");
      end else begin
        add_dec(int'($urandom % LIMIT), int'($urandom % LIMIT), 1'($urandom), "R2 random");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule